// File: doc/BRIEF.md
# Continuous-Phase FSK Tone Modulator

This block turns a serial bit stream into a stream of signed digital sine samples for an external digital-to-analog converter. A phase accumulator is advanced once per sample period by one of two fixed increments. The increment is chosen by the level of the serial transmit line: a high level selects a 1200 Hz tone and a low level selects a 2200 Hz tone. The top bits of the accumulator address a computed sine table.

The transmit line already carries framed asynchronous-serial bytes. Each line level therefore maps directly onto a tone, with no decoding in this block. When the tone changes, only the increment changes. The accumulator value carries over, so the output waveform keeps a continuous phase.

An active-low request-to-send input gates the modulator. While it is high, every sample is the midscale code and the accumulator is held at zero. When it goes low, the first sample produced is the phase-zero point. Samples are produced on a fixed sample-rate strobe: every `SAMPLE_DIV` clock cycles, each one marked by a single-cycle valid pulse.

Top module: `fsk_tone_mod`

## Requirements
- R1: During and right after reset, `sample_o` is 0 and `valid_o` is 0.
- R2: `valid_o` is a one-cycle pulse that repeats every `SAMPLE_DIV` clock cycles. `sample_o` changes only in a cycle where `valid_o` is high.
- R3: When `txd` is 1 at a sample strobe, the 24-bit accumulator advances by round(1200 * 2^24 / fs), where fs = `CLK_HZ` / `SAMPLE_DIV`.
- R4: When `txd` is 0 at a sample strobe, the accumulator advances by round(2200 * 2^24 / fs).
- R5: A change of tone keeps the accumulator value and changes only the increment. The accumulator wraps modulo 2^24.
- R6: Each sample is round(511 * sin(2*pi*p/256)) as a 10-bit two's-complement word. Here p is bits [23:16] of the accumulator value held before that strobe's update.
- R7: When `rts_n` is 1 at a sample strobe, the sample is 0 and the accumulator becomes 0.
- R8: The first strobe with `rts_n` at 0 after an idle strobe yields the phase-zero sample, which is 0. Later samples then follow the accumulator.
- R9: `rts_n` and `txd` are sampled only at the sample strobe. Level changes between strobes have no effect on the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_n | input | 1 | Active-low request-to-send; low enables modulation |
| txd | input | 1 | Serial transmit data; 1 selects 1200 Hz, 0 selects 2200 Hz |
| sample_o | output | OUT_W (10) | Signed sine sample, two's complement |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The assertions take `rts_n` and `txd` to be synchronous to `clk`, because the block has no synchronizer. They also take `SAMPLE_DIV` to be at least 2, so that valid pulses can never touch. The bench changes its inputs only on falling clock edges. After each valid pulse it settles the final levels well before the next strobe; the glitch patterns also toggle `txd` only within that window. The expected samples come from a bench-side accumulator that uses its own increments and its own sine values.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
    // Phase step per sample: round(tone * 2^acc_w / (clk / div))
    function automatic longint tone_step(longint tone_hz, longint clk_hz,
                                         longint div, int acc_w);
        return ((tone_hz << acc_w) * div + clk_hz / 2) / clk_hz;
    endfunction
endpackage

// File: rtl/fsk_sample_tick.sv
module fsk_sample_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    assign tick_o = (st_q.cnt == CW'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
    parameter int              ACC_W      = 24,
    parameter logic [ACC_W-1:0] STEP_MARK  = '0,
    parameter logic [ACC_W-1:0] STEP_SPACE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             mark_i,
    output logic [ACC_W-1:0] phase_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W-1:0] step_w;

    assign step_w  = mark_i ? STEP_MARK : STEP_SPACE;
    assign phase_o = st_q.acc;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (run_i) st_d.acc = st_q.acc + step_w;
            else       st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int OUT_W  = 10
) (
    input  logic [ADDR_W-1:0]       addr_i,
    output logic signed [OUT_W-1:0] data_o
);
    localparam int  DEPTH = 1 << ADDR_W;
    localparam real AMP   = real'((1 << (OUT_W - 1)) - 1);
    localparam real TWOPI = 6.283185307179586;

    logic signed [OUT_W-1:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam real VR = AMP * $sin(TWOPI * real'(g) / real'(DEPTH));
        localparam int  VI = (VR >= 0.0) ? $rtoi(VR + 0.5) : -$rtoi(0.5 - VR);
        assign table_w[g] = OUT_W'(VI);
    end

    assign data_o = table_w[addr_i];
endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int SAMPLE_DIV = 50,
    parameter int MARK_HZ    = 1200,
    parameter int SPACE_HZ   = 2200,
    parameter int ACC_W      = 24,
    parameter int ADDR_W     = 8,
    parameter int OUT_W      = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rts_n,
    input  logic                    txd,
    output logic signed [OUT_W-1:0] sample_o,
    output logic                    valid_o
);
    localparam logic [ACC_W-1:0] STEP_MARK =
        ACC_W'(fsk_pkg::tone_step(MARK_HZ, CLK_HZ, SAMPLE_DIV, ACC_W));
    localparam logic [ACC_W-1:0] STEP_SPACE =
        ACC_W'(fsk_pkg::tone_step(SPACE_HZ, CLK_HZ, SAMPLE_DIV, ACC_W));

    typedef struct packed {
        logic signed [OUT_W-1:0] sample;
        logic                    valid;
    } out_st_t;

    out_st_t st_d, st_q;
    logic                    tick_w;
    logic [ACC_W-1:0]        phase_w;
    logic signed [OUT_W-1:0] rom_w;

    fsk_sample_tick #(.DIV(SAMPLE_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    fsk_phase_acc #(
        .ACC_W      (ACC_W),
        .STEP_MARK  (STEP_MARK),
        .STEP_SPACE (STEP_SPACE)
    ) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_w),
        .run_i   (!rts_n),
        .mark_i  (txd),
        .phase_o (phase_w)
    );

    fsk_sine_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) rom_i (
        .addr_i (phase_w[ACC_W-1 -: ADDR_W]),
        .data_o (rom_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = tick_w;
        if (tick_w) st_d.sample = rts_n ? '0 : rom_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign valid_o  = st_q.valid;
endmodule

// File: rtl/fsk_tone_mod_chk.sv
module fsk_tone_mod_chk #(
    parameter int ACC_W = 24,
    parameter int OUT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rts_n,
    input logic                    tick,
    input logic [ACC_W-1:0]        phase,
    input logic signed [OUT_W-1:0] out_sample,
    input logic                    out_valid
);
    localparam int LIM = (1 << (OUT_W - 1)) - 1;

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r2_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> out_valid);

    a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !out_valid);

    a_r2_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    a_r5_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rts_n) |=> (out_sample == '0 && phase == '0));

    a_r8_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rts_n && phase == '0) |=> out_sample == '0);

    a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(out_sample) <= LIM) && (int'(out_sample) >= -LIM));
endmodule

bind fsk_tone_mod fsk_tone_mod_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rts_n      (rts_n),
    .tick       (tick_w),
    .phase      (phase_w),
    .out_sample (sample_o),
    .out_valid  (valid_o)
);

// File: tb/fsk_tone_mod_tb_top.sv
`timescale 1ns/1ps
module fsk_tone_mod_tb_top;
    localparam int CLK_HZ = 50_000_000;
    localparam int DIV    = 50;
    localparam int ACC_W  = 24;
    localparam int OUT_W  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rts_n = 1'b1;
    logic txd = 1'b1;
    logic signed [OUT_W-1:0] sample_o;
    logic valid_o;

    always #10 clk = ~clk;

    fsk_tone_mod #(.CLK_HZ(CLK_HZ), .SAMPLE_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .txd(txd),
        .sample_o(sample_o), .valid_o(valid_o)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    int sine_m[256];
    longint step1_m, step0_m, phase_m;
    longint cyc = 0;
    longint last_valid = -1;

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    initial begin
        real fs, v;
        fs = real'(CLK_HZ) / real'(DIV);
        step1_m = longint'($rtoi(1200.0 * 16777216.0 / fs + 0.5));
        step0_m = longint'($rtoi(2200.0 * 16777216.0 / fs + 0.5));
        for (int i = 0; i < 256; i++) begin
            v = 511.0 * $sin(2.0 * 3.141592653589793 * real'(i) / 256.0);
            sine_m[i] = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
        end
        phase_m = 0;
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops the expected sample for each valid pulse
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (last_valid >= 0)
                check((cyc - last_valid) == DIV, "R2 valid period",
                      int'(cyc - last_valid), DIV);
            last_valid = cyc;
            if (exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(sample_o) == e, t, int'(sample_o), e);
            end else begin
                check(sample_o == '0, "R7 idle before drive", int'(sample_o), 0);
            end
        end
    end

    // Driver: sets the levels for the next strobe and pushes the expectation
    task automatic drive(bit r, bit t, int n, string tag, bit glitch = 1'b0);
        for (int k = 0; k < n; k++) begin
            int e;
            @(negedge clk iff valid_o);
            @(negedge clk);
            if (glitch) begin
                rts_n = r;
                txd = ~t;
                repeat (8) @(negedge clk);
                txd = t;
                repeat (8) @(negedge clk);
                txd = ~t;
                repeat (8) @(negedge clk);
            end
            rts_n = r;
            txd = t;
            if (r) begin
                e = 0;
                phase_m = 0;
            end else begin
                e = sine_m[int'((phase_m >> 16) & 255)];
                phase_m = (phase_m + (t ? step1_m : step0_m)) & 64'hFF_FFFF;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sample_o == '0, "R1 reset sample", int'(sample_o), 0);
        check(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sample_o == '0, "R1 after reset sample", int'(sample_o), 0);

        drive(1'b1, 1'b1, 5, "R7 idle midscale");
        drive(1'b0, 1'b1, 1, "R8 first sample phase zero");
        drive(1'b0, 1'b1, 300, "R3 1200 Hz tone R6");
        drive(1'b0, 1'b0, 300, "R4 2200 Hz tone with wrap R6");
        for (int b = 0; b < 40; b++)
            drive(1'b0, b[1] ^ b[3], 3, "R5 tone switching continuity");
        drive(1'b0, 1'b1, 25, "R9 txd glitches ignored", 1'b1);
        drive(1'b0, 1'b0, 25, "R9 txd glitches ignored", 1'b1);
        drive(1'b1, 1'b0, 5, "R7 idle after run");
        drive(1'b0, 1'b0, 1, "R8 restart at phase zero");
        drive(1'b0, 1'b1, 200, "R5 restart continuity");
        drive(1'b1, 1'b1, 1, "R7 final idle");
        @(negedge clk iff valid_o);
        @(negedge clk);
        check(exp_q.size() == 0, "R2 all samples seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule